// File: doc/BRIEF.md
# ASCII Instrument Command Decoder

This block sits behind a talker/listener bus interface. It takes one received byte per strobe and parses instrument commands. A command is a three-letter upper-case mnemonic and a mode character, and it ends with a semicolon. The mode character is `?` when the instrument must get ready to send (a query). It is a single space when data will be sent to the instrument.

The block keeps a 13-bit waveform-memory address register. The address-setting command, followed by a space, carries a decimal argument. That argument replaces the register when it lies in 0..8191, and the data and octal transfers that follow use it. Every command, good or bad, is reported by a one-cycle pulse in the cycle after its terminator is accepted. A good command pulses the decoded-command output. A bad command pulses the error flag.

A device-clear input, or the device-clear command, sets the address to 0. The input also abandons any command that is partly parsed.

Top module: `ascii_cmd_decoder`

## Requirements
- R1: After reset, cmdValid, errFlag and cmdQuery are 0, cmdCode is 0 and addrReg is 0.
- R2: A recognised mnemonic followed by `?` and `;` gives cmdValid=1 with cmdQuery=1 for exactly one cycle after the `;` is accepted. The command codes are ADR=1, DAT=2, OCT=3, WRD=4 and DCL=5, and cmdCode is 0 whenever cmdValid is 0.
- R3: A recognised mnemonic followed by a space and then `;` (DAT, OCT, WRD or DCL) reports its code with cmdQuery=0.
- R4: `ADR`, a space, one or more decimal digits and `;` give cmdValid with code 1. addrReg takes the value of the digits, where value = value*10 + digit, and leading zeros are allowed. `ADR?;` reports code 1 with cmdQuery=1 and leaves addrReg unchanged.
- R5: An ADR argument greater than 8191, or an empty argument (`ADR ;`), raises errFlag for one cycle after `;`, and addrReg keeps its old value.
- R6: Any byte in an ADR argument that is neither a digit nor `;` raises errFlag at the next `;`, and addrReg keeps its old value.
- R7: An unrecognised mnemonic, including one in lower case, raises errFlag for one cycle after the next `;`. The block ignores every byte in between, and it decodes the command after that `;` normally.
- R8: A mode character other than `?` or space, or any extra byte between the mode character and `;` of a command without an argument, raises errFlag at the next `;`.
- R9: A `;` that arrives before a command is complete, including a lone `;`, raises errFlag. errFlag and cmdValid are never 1 together.
- R10: The DCL command sets addrReg to 0 in the cycle its pulse appears. The devClear input sets addrReg to 0 on the next cycle, clears any pulse and discards any partly received command.
- R11: A byte presented while byteValid is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | byteData holds a received byte this cycle |
| byteData | input | 8 | Received ASCII byte |
| devClear | input | 1 | Device clear: address to 0, parser to idle |
| cmdValid | output | 1 | One-cycle pulse: a good command ended |
| cmdCode | output | 3 | Decoded command code, valid with cmdValid |
| cmdQuery | output | 1 | 1 for a `?` command, 0 for a space command |
| addrReg | output | 13 | Waveform-memory address register |
| errFlag | output | 1 | One-cycle pulse: a bad command ended |

## Verification
The bench sends every legal ADR argument from 0 to 8191. It then sends the values just past the top, 8192 and far larger, which a design that lets the accumulator wrap would quietly load as small addresses. Each mnemonic letter position is swept through the whole alphabet, so a decoder that matches only part of a mnemonic shows up as a false decode. The remaining checks cover an early terminator, a bad mode byte, a non-digit inside the argument, device clear in the middle of an argument, and bytes presented with the strobe low. Any one of these would otherwise move the address or leave the parser out of step for the following command.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_ADR  = 3'd1,
    CMD_DAT  = 3'd2,
    CMD_OCT  = 3'd3,
    CMD_WRD  = 3'd4,
    CMD_DCL  = 3'd5
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       accClr;
    logic       accStep;
    logic [3:0] digit;
    logic       addrLoad;
    logic       addrZero;
  } dp_strobe_t;

  function automatic cmd_e lookupMnem(input logic [23:0] m);
    case (m)
      "ADR":   return CMD_ADR;
      "DAT":   return CMD_DAT;
      "OCT":   return CMD_OCT;
      "WRD":   return CMD_WRD;
      "DCL":   return CMD_DCL;
      default: return CMD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/cmd_ctrl.sv
module cmd_ctrl
  import cmd_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  input  logic       devClear,
  input  logic       accOvf,
  output dp_strobe_t strobe,
  output logic       cmdValid,
  output cmd_e       cmdCode,
  output logic       cmdQuery,
  output logic       errFlag
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_C1, ST_C2, ST_MODE, ST_TERM, ST_ARG0, ST_ARG, ST_SKIP
  } state_e;

  state_e      state, nextState;
  logic [15:0] mnem, nextMnem;
  cmd_e        selCode, nextSel, hitCode;
  logic        selQuery, nextQuery;
  logic        pulseValid, pulseErr;
  logic        isTerm, isDigit;

  assign isTerm  = (byteData == 8'h3B);
  assign isDigit = (byteData >= 8'h30) && (byteData <= 8'h39);
  assign hitCode = lookupMnem({mnem, byteData});

  always_comb begin
    nextState  = state;
    nextMnem   = mnem;
    nextSel    = selCode;
    nextQuery  = selQuery;
    pulseValid = 1'b0;
    pulseErr   = 1'b0;
    strobe     = '0;
    strobe.digit = byteData[3:0];
    if (byteValid) begin
      case (state)
        ST_IDLE: if (isTerm) pulseErr = 1'b1;
                 else begin nextMnem[15:8] = byteData; nextState = ST_C1; end
        ST_C1:   if (isTerm) begin pulseErr = 1'b1; nextState = ST_IDLE; end
                 else begin nextMnem[7:0] = byteData; nextState = ST_C2; end
        ST_C2:   if (isTerm) begin pulseErr = 1'b1; nextState = ST_IDLE; end
                 else begin
                   nextSel   = hitCode;
                   nextState = (hitCode == CMD_NONE) ? ST_SKIP : ST_MODE;
                 end
        ST_MODE: begin
          strobe.accClr = 1'b1;
          if (isTerm) begin pulseErr = 1'b1; nextState = ST_IDLE; end
          else if (byteData == 8'h3F) begin nextQuery = 1'b1; nextState = ST_TERM; end
          else if (byteData == 8'h20) begin
            nextQuery = 1'b0;
            nextState = (selCode == CMD_ADR) ? ST_ARG0 : ST_TERM;
          end
          else nextState = ST_SKIP;
        end
        ST_TERM: if (isTerm) begin
                   pulseValid      = 1'b1;
                   strobe.addrZero = (selCode == CMD_DCL);
                   nextState       = ST_IDLE;
                 end
                 else nextState = ST_SKIP;
        ST_ARG0: if (isDigit) begin strobe.accStep = 1'b1; nextState = ST_ARG; end
                 else if (isTerm) begin pulseErr = 1'b1; nextState = ST_IDLE; end
                 else nextState = ST_SKIP;
        ST_ARG:  if (isDigit) strobe.accStep = 1'b1;
                 else if (isTerm) begin
                   if (accOvf) pulseErr = 1'b1;
                   else begin pulseValid = 1'b1; strobe.addrLoad = 1'b1; end
                   nextState = ST_IDLE;
                 end
                 else nextState = ST_SKIP;
        ST_SKIP: if (isTerm) begin pulseErr = 1'b1; nextState = ST_IDLE; end
        default: nextState = ST_IDLE;
      endcase
    end
    if (devClear) begin
      strobe          = '0;
      strobe.addrZero = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || devClear) begin
      state    <= ST_IDLE;
      mnem     <= '0;
      selCode  <= CMD_NONE;
      selQuery <= 1'b0;
      cmdValid <= 1'b0;
      cmdCode  <= CMD_NONE;
      cmdQuery <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      state    <= nextState;
      mnem     <= nextMnem;
      selCode  <= nextSel;
      selQuery <= nextQuery;
      cmdValid <= pulseValid;
      cmdCode  <= pulseValid ? selCode : CMD_NONE;
      cmdQuery <= pulseValid & selQuery;
      errFlag  <= pulseErr;
    end
  end

  // R2: a command report lasts one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |=> !cmdValid);
  // R9: never both outcomes at once
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmdValid && errFlag));
  // R7: an error is only reported right after an accepted terminator
  a_r7_err_after_term: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |-> $past(byteValid && byteData == 8'h3B && !devClear));
  // R2: a reported command carries a real code
  a_r2_code_present: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |-> cmdCode != CMD_NONE);

endmodule

// File: rtl/cmd_dpath.sv
module cmd_dpath
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W = 13
)(
  input  logic              clk,
  input  logic              rst_n,
  input  dp_strobe_t        strobe,
  output logic              accOvf,
  output logic [ADDR_W-1:0] addrReg
);

  localparam int WIDE_W = ADDR_W + 4;
  localparam logic [WIDE_W-1:0] ADDR_MAX = WIDE_W'((1 << ADDR_W) - 1);

  logic [ADDR_W-1:0] acc;
  logic [WIDE_W-1:0] wide;

  assign wide = WIDE_W'(acc) * WIDE_W'(10) + WIDE_W'(strobe.digit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      accOvf <= 1'b0;
    end else if (strobe.accClr) begin
      acc    <= '0;
      accOvf <= 1'b0;
    end else if (strobe.accStep && !accOvf) begin
      if (wide > ADDR_MAX) accOvf <= 1'b1;
      else                 acc    <= wide[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               addrReg <= '0;
    else if (strobe.addrZero) addrReg <= '0;
    else if (strobe.addrLoad) addrReg <= acc;
  end

  // R5: once out of range the argument stays rejected until a new command
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (accOvf && !strobe.accClr) |=> accOvf);

endmodule

// File: rtl/ascii_cmd_decoder.sv
module ascii_cmd_decoder
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W = 13
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              devClear,
  output logic              cmdValid,
  output logic [2:0]        cmdCode,
  output logic              cmdQuery,
  output logic [ADDR_W-1:0] addrReg,
  output logic              errFlag
);

  dp_strobe_t strobe;
  logic       accOvf;
  cmd_e       codeE;

  cmd_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .byteData(byteData),
    .devClear(devClear), .accOvf(accOvf), .strobe(strobe),
    .cmdValid(cmdValid), .cmdCode(codeE), .cmdQuery(cmdQuery), .errFlag(errFlag)
  );

  cmd_dpath #(.ADDR_W(ADDR_W)) i_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .accOvf(accOvf), .addrReg(addrReg)
  );

  assign cmdCode = codeE;

  // R10: device clear empties the address and any report
  a_r10_dev_clear: assert property (@(posedge clk) disable iff (!rst_n)
    devClear |=> (addrReg == '0 && !cmdValid && !errFlag));
  // R4: the address moves only with an ADR/DCL report or a device clear
  a_r4_addr_only_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (addrReg != $past(addrReg)) |->
      ($past(devClear) || (cmdValid && (cmdCode == 3'(CMD_ADR) || cmdCode == 3'(CMD_DCL)))));

endmodule

// File: tb/test_ascii_cmd_decoder.sv
module test_ascii_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = 8'h00;
  logic        devClear = 1'b0;
  logic        cmdValid, cmdQuery, errFlag;
  logic [2:0]  cmdCode;
  logic [12:0] addrReg;

  int checks = 0;
  int errors = 0;
  int expAddr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ascii_cmd_decoder i_ascii_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .byteData(byteData),
    .devClear(devClear), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdQuery(cmdQuery), .addrReg(addrReg), .errFlag(errFlag)
  );

  function automatic int knownCode(string m);
    if (m == "ADR") return 1;
    if (m == "DAT") return 2;
    if (m == "OCT") return 3;
    if (m == "WRD") return 4;
    if (m == "DCL") return 5;
    return 0;
  endfunction

  task automatic sendByte(input logic [7:0] b, input logic v = 1'b1);
    byteValid = v;
    byteData  = b;
    @(posedge clk);
    #1;
    byteValid = 1'b0;
  endtask

  task automatic sendStr(input string s);
    for (int i = 0; i < s.len(); i++) sendByte(s[i]);
  endtask

  task automatic checkOut(input string tag, input bit v, input int code,
                          input bit q, input bit e, input int addr);
    checks++;
    if (cmdValid !== v || int'(cmdCode) != code || cmdQuery !== q ||
        errFlag !== e || int'(addrReg) != addr) begin
      errors++;
      $display("FAIL %s: got valid=%0b code=%0d query=%0b err=%0b addr=%0d exp valid=%0b code=%0d query=%0b err=%0b addr=%0d",
               tag, cmdValid, cmdCode, cmdQuery, errFlag, addrReg, v, code, q, e, addr);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    checkOut("R1 reset", 0, 0, 0, 0, 0);

    // R2 / R3: every known mnemonic in both modes
    sendStr("DAT?;"); checkOut("R2 DAT?", 1, 2, 1, 0, expAddr);
    sendStr("OCT?;"); checkOut("R2 OCT?", 1, 3, 1, 0, expAddr);
    sendStr("WRD?;"); checkOut("R2 WRD?", 1, 4, 1, 0, expAddr);
    sendStr("DAT ;"); checkOut("R3 DAT space", 1, 2, 0, 0, expAddr);
    sendStr("OCT ;"); checkOut("R3 OCT space", 1, 3, 0, 0, expAddr);
    sendStr("WRD ;"); checkOut("R3 WRD space", 1, 4, 0, 0, expAddr);
    sendByte("X");    checkOut("R2 pulse drops", 0, 0, 0, 0, expAddr);
    sendStr(";");     checkOut("R9 partial then term", 0, 0, 0, 1, expAddr);

    // R4: exhaustive address sweep
    for (int v = 0; v < 8192; v++) begin
      sendStr($sformatf("ADR %0d;", v));
      expAddr = v;
      checkOut($sformatf("R4 ADR %0d", v), 1, 1, 0, 0, expAddr);
    end
    sendStr("ADR 1234;"); expAddr = 1234;
    checkOut("R4 ADR 1234", 1, 1, 0, 0, expAddr);
    sendStr("ADR?;");    checkOut("R4 ADR query keeps addr", 1, 1, 1, 0, expAddr);
    sendStr("ADR 0008191;"); expAddr = 8191;
    checkOut("R4 leading zeros", 1, 1, 0, 0, expAddr);

    // R5: out of range and empty
    sendStr("ADR 8192;");      checkOut("R5 8192", 0, 0, 0, 1, expAddr);
    sendStr("ADR 65535;");     checkOut("R5 65535", 0, 0, 0, 1, expAddr);
    sendStr("ADR 999999999;"); checkOut("R5 huge", 0, 0, 0, 1, expAddr);
    sendStr("ADR ;");          checkOut("R5 empty", 0, 0, 0, 1, expAddr);
    sendStr("ADR 77;"); expAddr = 77;
    checkOut("R5 recovery", 1, 1, 0, 0, expAddr);

    // R6: non-digits in argument
    sendStr("ADR 12X4;"); checkOut("R6 letter", 0, 0, 0, 1, expAddr);
    sendStr("ADR -5;");   checkOut("R6 sign", 0, 0, 0, 1, expAddr);
    sendStr("ADR 5 ;");   checkOut("R6 trailing space", 0, 0, 0, 1, expAddr);

    // R7: unknown mnemonics, each letter position swept
    for (int p = 0; p < 3; p++) begin
      for (int l = 0; l < 26; l++) begin
        string m;
        int c;
        m = "DAT";
        m[p] = 8'(65 + l);
        c = knownCode(m);
        sendStr({m, "?;"});
        if (c == 0) checkOut({"R7 unknown ", m}, 0, 0, 0, 1, expAddr);
        else        checkOut({"R7 known ", m}, 1, c, 1, 0, expAddr);
      end
    end
    sendStr("dat?;");        checkOut("R7 lower case", 0, 0, 0, 1, expAddr);
    sendStr("XYZ 12 ADR 5"); checkOut("R7 bytes ignored", 0, 0, 0, 0, expAddr);
    sendStr(";");            checkOut("R7 error at term", 0, 0, 0, 1, expAddr);
    sendStr("DAT?;");        checkOut("R7 next decodes", 1, 2, 1, 0, expAddr);

    // R8: bad mode, extra bytes
    sendStr("DATX;");  checkOut("R8 bad mode", 0, 0, 0, 1, expAddr);
    sendStr("DAT?5;"); checkOut("R8 extra byte", 0, 0, 0, 1, expAddr);
    sendStr("OCT  ;"); checkOut("R8 two spaces", 0, 0, 0, 1, expAddr);

    // R9: early terminators
    sendStr(";");    checkOut("R9 lone term", 0, 0, 0, 1, expAddr);
    sendStr("DA;");  checkOut("R9 two letters", 0, 0, 0, 1, expAddr);
    sendStr("DAT;"); checkOut("R9 no mode", 0, 0, 0, 1, expAddr);

    // R10: device clear command and input
    sendStr("DCL ;"); expAddr = 0;
    checkOut("R10 DCL command", 1, 5, 0, 0, expAddr);
    sendStr("ADR 4000;"); expAddr = 4000;
    checkOut("R10 setup", 1, 1, 0, 0, expAddr);
    sendStr("ADR 12");
    devClear = 1'b1;
    @(posedge clk); #1 devClear = 1'b0;
    expAddr = 0;
    checkOut("R10 devClear input", 0, 0, 0, 0, expAddr);
    sendStr("34;");  checkOut("R10 partial discarded", 0, 0, 0, 1, expAddr);
    sendStr("DAT?;");
    devClear = 1'b1;
    @(posedge clk); #1 devClear = 1'b0;
    checkOut("R10 clears pulse", 0, 0, 0, 0, expAddr);

    // R11: strobe low bytes ignored
    sendStr("DA");
    sendByte(";", 1'b0);
    sendByte("X", 1'b0);
    sendStr("T?;");
    checkOut("R11 gaps ignored", 1, 2, 1, 0, expAddr);
    sendByte(";", 1'b0);
    checkOut("R11 term without strobe", 0, 0, 0, 0, expAddr);

    finishRun();
  end

endmodule